// File: doc/BRIEF.md
# Ratiometric Pulse-Width Bus Word Receiver

This block takes words off a three-level serial bus whose line levels have already been turned into 2-bit codes by comparators outside it. It runs from a free-running internal clock whose frequency is not known precisely. It therefore never compares a bit against a fixed bit period. Instead it counts the clocks that each bit spends in its low phase and in its high phase, and it decides the bit from the larger of the two. This ratio test holds over a wide spread of bus rates and clock frequencies.

There are two bus inputs, an upstream one and a downstream one. Either of them may carry the waveform, and the other is then expected to sit at Idle. When both are active, the upstream input is used. Each input goes through its own two-flop synchronizer and a stability filter. The two filtered levels are then merged into one stream, which drives a word state machine with five states:

- REST: the bus is idle.
- ARM: a High has been seen after Idle.
- LOW: counting the low phase of a bit.
- HIGH: counting the high phase of a bit.
- DRAIN: the frame has been rejected, and the machine waits for Idle.

The transitions are:

- REST→ARM on High.
- REST→DRAIN on Low.
- ARM→LOW on Low.
- ARM→REST on Idle.
- LOW→HIGH on High.
- LOW→REST on Idle (abort).
- HIGH→LOW on Low (bit done).
- HIGH→DRAIN on Low once the bit store is full.
- HIGH→REST on Idle (word done).
- DRAIN→REST on Idle.

When a word of legal length completes, the block presents the word, its bit count and the source port, together with a one-cycle strobe. These outputs hold their values until the next legal word arrives.

Top module: `pwbus_rx`

## Requirements
- R1: Level codes are 2'b00 Idle, 2'b01 Signal High, 2'b10 Signal Low, and 2'b11 is treated as Idle. A word begins only after Idle→High→Low. A Low that directly follows Idle starts nothing, and the block then waits for Idle.
- R2: A bit decodes as 1 when its high phase lasts more clocks than its low phase. Otherwise it decodes as 0, which includes equal lengths.
- R3: The first bit received lands in word_o[n-1] and the last in word_o[0], where n is the bit count. Bits above n-1 are zero, and len_o carries n.
- R4: A High→Idle move ends the word. A legal word raises valid_o for exactly one clock, and word_o, len_o and from_dn_o hold until the next strobe.
- R5: Only bit counts of 12 or 20 produce a strobe. Any other count is dropped without a strobe.
- R6: When a 21st bit arrives, shifting stops and the word is discarded. No strobe follows, and the next word is received normally.
- R7: A Low→Idle move inside a word aborts it without a strobe.
- R8: Signalling on either input alone is received. from_dn_o is 1 when the word came in on the downstream input and 0 when it came in on the upstream input.
- R9: A new level must persist for two consecutive synchronized clocks before it is accepted. A one-clock glitch has no effect.
- R10: The low and high phase counters (CNT_W bits) saturate at their maximum instead of wrapping.
- R11: After reset, valid_o, word_o, len_o and from_dn_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_up_i | input | 2 | Level code of the upstream bus input |
| lvl_dn_i | input | 2 | Level code of the downstream bus input |
| word_o | output | MAX_BITS | Received word, right-aligned |
| len_o | output | clog2(MAX_BITS+1) | Bit count of the received word |
| valid_o | output | 1 | One-cycle strobe for a legal word |
| from_dn_o | output | 1 | Word came in on the downstream input |

## Verification
The embedded assertions check on every cycle that:

- a strobe lasts one clock and carries a legal length;
- a strobe can only come out of the HIGH state;
- the bit counter never passes its limit;
- the phase counters hold at their maximum;
- an abort returns to REST silently;
- a filtered level changes only after the synchronizer has agreed with it for two clocks.

Whether each bit value is correct, how the word is aligned, which port is flagged, how a saturated tie is decided, how glitches are rejected, and how the block behaves once an over-long frame is over are things only the bench's directed and random frames can show.

// File: rtl/pwbus_pkg.sv
package pwbus_pkg;
    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_LOW  = 2'b10,
        LVL_RSVD = 2'b11
    } lvl_e;

    typedef enum logic [2:0] {
        ST_REST,
        ST_ARM,
        ST_LOW,
        ST_HIGH,
        ST_DRAIN
    } rx_state_e;
endpackage

// File: rtl/pwbus_level_filter.sv
module pwbus_level_filter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] raw_i,
    output logic [1:0] lvl_o
);
    logic [1:0] s1_q, s2_q, s3_q, lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 2'b00;
            s2_q  <= 2'b00;
            s3_q  <= 2'b00;
            lvl_q <= 2'b00;
        end else begin
            s1_q <= raw_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (s2_q == s3_q && s2_q != lvl_q) begin
                lvl_q <= s2_q;
            end
        end
    end

    assign lvl_o = lvl_q;

    // R9: an accepted level was seen by the synchronizer on two clocks
    p_filter_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> ($past(s2_q) == lvl_q && $past(s3_q) == lvl_q));
endmodule

// File: rtl/pwbus_port_merge.sv
module pwbus_port_merge
    import pwbus_pkg::*;
(
    input  logic [1:0] up_i,
    input  logic [1:0] dn_i,
    output lvl_e       lvl_o,
    output logic       dn_sel_o
);
    lvl_e up_n, dn_n;

    always_comb begin
        up_n = (up_i == LVL_RSVD) ? LVL_IDLE : lvl_e'(up_i);
        dn_n = (dn_i == LVL_RSVD) ? LVL_IDLE : lvl_e'(dn_i);
        if (up_n != LVL_IDLE) begin
            lvl_o    = up_n;
            dn_sel_o = 1'b0;
        end else begin
            lvl_o    = dn_n;
            dn_sel_o = (dn_n != LVL_IDLE);
        end
    end
endmodule

// File: rtl/pwbus_word_fsm.sv
module pwbus_word_fsm
    import pwbus_pkg::*;
#(
    parameter int MAX_BITS   = 20,
    parameter int SHORT_BITS = 12,
    parameter int CNT_W      = 8,
    localparam int LEN_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lvl_e                lvl_i,
    input  logic                dn_sel_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic [LEN_W-1:0]    len_o,
    output logic                valid_o,
    output logic                from_dn_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [LEN_W-1:0] MAX_N   = LEN_W'(MAX_BITS);
    localparam logic [LEN_W-1:0] SHORT_N = LEN_W'(SHORT_BITS);

    rx_state_e           state_q, state_d;
    logic [CNT_W-1:0]    lo_q, hi_q;
    logic [LEN_W-1:0]    nbits_q, nbits_nx;
    logic [MAX_BITS-1:0] shreg_q, word_q;
    logic [LEN_W-1:0]    len_q;
    logic                valid_q, dn_q, from_dn_q;
    logic                bit_val, full, len_ok;

    assign bit_val  = (hi_q > lo_q);
    assign full     = (nbits_q == MAX_N);
    assign nbits_nx = nbits_q + 1'b1;
    assign len_ok   = !full && (nbits_nx == SHORT_N || nbits_nx == MAX_N);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST: begin
                if (lvl_i == LVL_HIGH)     state_d = ST_ARM;
                else if (lvl_i == LVL_LOW) state_d = ST_DRAIN;
            end
            ST_ARM: begin
                if (lvl_i == LVL_LOW)       state_d = ST_LOW;
                else if (lvl_i == LVL_IDLE) state_d = ST_REST;
            end
            ST_LOW: begin
                if (lvl_i == LVL_HIGH)      state_d = ST_HIGH;
                else if (lvl_i == LVL_IDLE) state_d = ST_REST;
            end
            ST_HIGH: begin
                if (lvl_i == LVL_LOW)       state_d = full ? ST_DRAIN : ST_LOW;
                else if (lvl_i == LVL_IDLE) state_d = ST_REST;
            end
            ST_DRAIN: begin
                if (lvl_i == LVL_IDLE) state_d = ST_REST;
            end
            default: state_d = ST_REST;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            nbits_q   <= '0;
            shreg_q   <= '0;
            word_q    <= '0;
            len_q     <= '0;
            valid_q   <= 1'b0;
            dn_q      <= 1'b0;
            from_dn_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_REST: begin
                    if (lvl_i == LVL_HIGH) begin
                        dn_q    <= dn_sel_i;
                        nbits_q <= '0;
                        shreg_q <= '0;
                    end
                end
                ST_ARM: begin
                    if (lvl_i == LVL_LOW) lo_q <= '0;
                end
                ST_LOW: begin
                    if (lvl_i == LVL_LOW && lo_q != CNT_MAX) lo_q <= lo_q + 1'b1;
                    if (lvl_i == LVL_HIGH) hi_q <= '0;
                end
                ST_HIGH: begin
                    if (lvl_i == LVL_HIGH && hi_q != CNT_MAX) hi_q <= hi_q + 1'b1;
                    if (lvl_i == LVL_LOW && !full) begin
                        shreg_q <= {shreg_q[MAX_BITS-2:0], bit_val};
                        nbits_q <= nbits_nx;
                        lo_q    <= '0;
                    end
                    if (lvl_i == LVL_IDLE && len_ok) begin
                        word_q    <= {shreg_q[MAX_BITS-2:0], bit_val};
                        len_q     <= nbits_nx;
                        from_dn_q <= dn_q;
                        valid_q   <= 1'b1;
                    end
                end
                ST_DRAIN: ;
                default: ;
            endcase
        end
    end

    assign word_o    = word_q;
    assign len_o     = len_q;
    assign valid_o   = valid_q;
    assign from_dn_o = from_dn_q;

    // R5: a strobe only ever carries a legal length
    p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (len_q == SHORT_N || len_q == MAX_N));
    // R4: strobe lasts a single clock
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R4: a strobe follows the end of a high phase
    p_strobe_from_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(state_q) == ST_HIGH);
    // R6: the bit count never passes its limit
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nbits_q <= MAX_N);
    // R10: a full low counter holds its value
    p_low_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && lvl_i == LVL_LOW && lo_q == CNT_MAX) |=> lo_q == CNT_MAX);
    // R10: a full high counter holds its value
    p_high_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && lvl_i == LVL_HIGH && hi_q == CNT_MAX) |=> hi_q == CNT_MAX);
    // R7: Low to Idle inside a word aborts silently
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && lvl_i == LVL_IDLE) |=> (!valid_q && state_q == ST_REST));
endmodule

// File: rtl/pwbus_rx.sv
module pwbus_rx #(
    parameter int MAX_BITS   = 20,
    parameter int SHORT_BITS = 12,
    parameter int CNT_W      = 8,
    localparam int LEN_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          lvl_up_i,
    input  logic [1:0]          lvl_dn_i,
    output logic [MAX_BITS-1:0] word_o,
    output logic [LEN_W-1:0]    len_o,
    output logic                valid_o,
    output logic                from_dn_o
);
    localparam int NPORTS = 2;

    logic [1:0] raw_arr [NPORTS];
    logic [1:0] flt_arr [NPORTS];
    pwbus_pkg::lvl_e merged;
    logic            dn_sel;

    assign raw_arr[0] = lvl_up_i;
    assign raw_arr[1] = lvl_dn_i;

    for (genvar g = 0; g < NPORTS; g++) begin : g_filt
        pwbus_level_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_arr[g]),
            .lvl_o (flt_arr[g])
        );
    end

    pwbus_port_merge u_merge (
        .up_i     (flt_arr[0]),
        .dn_i     (flt_arr[1]),
        .lvl_o    (merged),
        .dn_sel_o (dn_sel)
    );

    pwbus_word_fsm #(
        .MAX_BITS   (MAX_BITS),
        .SHORT_BITS (SHORT_BITS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (merged),
        .dn_sel_i  (dn_sel),
        .word_o    (word_o),
        .len_o     (len_o),
        .valid_o   (valid_o),
        .from_dn_o (from_dn_o)
    );
endmodule

// File: tb/pwbus_rx_bench.sv
module pwbus_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] IDL = 2'b00, HI = 2'b01, LO = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  up = IDL, dn = IDL;
    logic [19:0] word_o;
    logic [4:0]  len_o;
    logic        valid_o, from_dn_o;

    int checks = 0, errors = 0, strobes = 0;
    int lo_d [32];
    int hi_d [32];
    int glitch_bit = -1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwbus_rx u_pwbus_rx (
        .clk(clk), .rst_n(rst_n), .lvl_up_i(up), .lvl_dn_i(dn),
        .word_o(word_o), .len_o(len_o), .valid_o(valid_o), .from_dn_o(from_dn_o)
    );

    always @(negedge clk) if (valid_o) strobes++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input int port, input logic [1:0] code, input int cyc);
        if (port == 0) begin up = code; dn = IDL; end
        else begin dn = code; up = IDL; end
        repeat (cyc) @(negedge clk);
    endtask

    task automatic send_raw(input int port, input int n);
        drive(port, HI, 4);
        for (int i = 0; i < n; i++) begin
            drive(port, LO, lo_d[i]);
            if (i == glitch_bit) begin
                drive(port, HI, hi_d[i] / 2);
                drive(port, LO, 1);
                drive(port, HI, hi_d[i] - hi_d[i] / 2);
            end else begin
                drive(port, HI, hi_d[i]);
            end
        end
        drive(port, IDL, 12);
    endtask

    function automatic logic exp_legal(input int n);
        return (n == 12 || n == 20);
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] pat, input int n);
        return pat & ((32'd1 << n) - 1);
    endfunction

    task automatic fill(input logic [31:0] pat, input int n, input int u);
        for (int i = 0; i < n; i++) begin
            int j0 = $urandom_range(0, 1);
            int j1 = $urandom_range(0, 1);
            if (pat[n-1-i]) begin lo_d[i] = u + j0;     hi_d[i] = 2 * u + j1; end
            else            begin lo_d[i] = 2 * u + j0; hi_d[i] = u + j1;     end
        end
    endtask

    // sends pat (first bit = pat[n-1]) and checks the outcome
    task automatic run_word(input int port, input logic [31:0] pat, input int n,
                            input int u, input string req);
        int s0 = strobes;
        fill(pat, n, u);
        send_raw(port, n);
        if (exp_legal(n)) begin
            chk({req, " strobe count (R4)"}, strobes - s0, 1);
            chk({req, " word (R2,R3)"}, {12'd0, word_o}, exp_word(pat, n));
            chk({req, " length (R3)"}, {27'd0, len_o}, n);
            chk({req, " port flag (R8)"}, {31'd0, from_dn_o}, port);
        end else begin
            chk({req, " no strobe (R5,R6)"}, strobes - s0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 valid", {31'd0, valid_o}, 0);
        chk("R11 word", {12'd0, word_o}, 0);
        chk("R11 len", {27'd0, len_o}, 0);
        chk("R11 flag", {31'd0, from_dn_o}, 0);

        run_word(0, 32'h00A5C, 12, 4, "R3 up 12-bit");
        run_word(1, 32'hF0C3A, 20, 3, "R8 down 20-bit");
        run_word(0, 32'h00FFF, 12, 5, "R2 all ones");
        run_word(1, 32'h00000, 12, 5, "R2 all zeros");
        foreach (lo_d[k]) begin lo_d[k] = 0; hi_d[k] = 0; end
        // R5 illegal lengths
        run_word(0, 32'h5A5, 11, 3, "R5 len11");
        run_word(0, 32'h1A5A, 13, 3, "R5 len13");
        run_word(1, 32'h7AAAA, 19, 3, "R5 len19");
        run_word(0, 32'h1, 1, 3, "R5 len1");
        // R6 over-long frames, then recovery
        run_word(0, 32'h1FFFFF, 21, 3, "R6 len21");
        run_word(1, 32'h1ABCDEF, 25, 3, "R6 len25");
        run_word(0, 32'hABCDE, 20, 4, "R6 recovery");

        // R7 abort: Low straight to Idle inside a word
        s0 = strobes;
        drive(0, HI, 4); drive(0, LO, 6); drive(0, HI, 6); drive(0, LO, 5); drive(0, IDL, 12);
        chk("R7 abort no strobe", strobes - s0, 0);
        // R1 Idle directly to Low starts nothing
        s0 = strobes;
        drive(1, LO, 6); drive(1, HI, 6); drive(1, LO, 3); drive(1, HI, 6); drive(1, IDL, 12);
        chk("R1 no start from Low", strobes - s0, 0);
        // R1 reserved code acts as Idle: word ends on 2'b11
        s0 = strobes;
        fill(32'h0C3, 12, 4);
        drive(0, HI, 4);
        for (int i = 0; i < 12; i++) begin drive(0, LO, lo_d[i]); drive(0, HI, hi_d[i]); end
        drive(0, 2'b11, 12);
        drive(0, IDL, 4);
        chk("R1 reserved ends word", strobes - s0, 1);
        chk("R1 reserved word", {12'd0, word_o}, 32'h0C3);

        // R2 tie decodes 0, one extra clock decodes 1
        fill(32'h0, 12, 3);
        for (int i = 0; i < 12; i++) begin lo_d[i] = 5; hi_d[i] = (i == 3) ? 6 : 5; end
        s0 = strobes;
        send_raw(0, 12);
        chk("R2 tie and margin", {12'd0, word_o}, 32'h100);

        // R10 saturation: both phases past the limit tie, giving 0
        fill(32'hFFF, 12, 3);
        lo_d[0] = 280; hi_d[0] = 300;
        send_raw(1, 12);
        chk("R10 saturated tie", {12'd0, word_o}, 32'h7FF);

        // R9 one-clock glitch at rest and inside a high phase
        s0 = strobes;
        drive(0, HI, 1); drive(0, IDL, 12);
        chk("R9 rest glitch", strobes - s0, 0);
        fill(32'h9A5, 12, 5);
        glitch_bit = 4;
        hi_d[4] = 12;
        s0 = strobes;
        send_raw(0, 12);
        glitch_bit = -1;
        chk("R9 glitch count", strobes - s0, 1);
        chk("R9 glitch word", {12'd0, word_o}, 32'h9A5);

        // random frames
        for (int t = 0; t < 40; t++) begin
            int sel = $urandom_range(0, 9);
            int n = (sel < 4) ? 12 : (sel < 8) ? 20 : $urandom_range(1, 24);
            run_word($urandom_range(0, 1), $urandom, n, $urandom_range(3, 10), "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule